// File: doc/BRIEF.md
# DMA Channel Trigger Request Logic

This block turns start events into transfer requests for every channel of a multi-channel DMA controller. Each channel has a sticky pending flag. Two kinds of event set it. Software can write a 1 to the channel's bit at the trigger address. A rising edge on the peripheral interrupt line chosen by the channel's selector field also sets it. Each channel owns a group of `2**SEL_W` interrupt lines, and its selector picks one line from that group.

A channel takes events only when it is armed. It is armed when its controller enable bit is set in this block and its descriptor channel enable input (`chen`) is high. Events that arrive while the channel is not armed are dropped. The pending flag is shown to the channel arbiter as `req`, gated by both enables. The flag clears once the arbiter accepts the request with `ack`. An event in the same cycle as the acceptance keeps the flag set.

Top module: `dma_trig_req`

## Requirements
- R1: After synchronous reset, `trg_pend` and `req` are all 0. Every controller enable bit is 0 and every selector field is 0.
- R2: A write with `wr_addr`=1 and `wr_data[c]`=1 to an armed channel c sets `trg_pend[c]` at the next clock edge.
- R3: A write of 0 to a bit at `wr_addr`=1 leaves that channel's flag unchanged.
- R4: A 0-to-1 change on the selected line `hw_src[c*2**SEL_W + sel_c]` of an armed channel sets `trg_pend[c]` at the next edge. A line that stays high sets the flag only once.
- R5: The selector of channel c is written with `wr_addr`=2 in bits `wr_data[c*SEL_W +: SEL_W]`. Edges on the unselected lines of the channel's group have no effect.
- R6: A software or hardware event on a channel whose controller enable is 0, or whose `chen` is 0, is discarded and does not set the flag.
- R7: `req[c]` is high exactly when `trg_pend[c]`, the controller enable of c and `chen[c]` are all high. It follows `chen` in the same cycle.
- R8: A pending flag holds until `req[c]` and `ack[c]` are high together. It then clears at that edge.
- R9: If a new event for channel c arrives in the same cycle that its request is accepted, `trg_pend[c]` stays 1.
- R10: A write with `wr_addr`=0 loads all controller enable bits at once from `wr_data[NUM_CH-1:0]`. Address 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 enables, 1 trigger, 2 selectors |
| wr_data | input | NUM_CH*SEL_W | Write data |
| hw_src | input | NUM_CH*2**SEL_W | Peripheral interrupt lines, grouped per channel |
| chen | input | NUM_CH | Descriptor channel enable per channel |
| ack | input | NUM_CH | Arbiter acceptance per channel |
| req | output | NUM_CH | Transfer request per channel |
| trg_pend | output | NUM_CH | Pending trigger flag per channel |

## Verification
The bench builds the block with NUM_CH=3 and SEL_W=2, so the channel count is not a power of two. With those values the 6-bit selector register and the 12 interrupt lines are small enough for random writes to hit every selector value on every channel. Twelve lines also let random stimulus produce frequent edges on both selected and unselected lines. These values also make it likely that an event, a dropped `chen` and an `ack` fall in the same cycle. Directed cases cover held levels, writes of zero, unarmed events and an event that coincides with acceptance.

// File: rtl/dtr_pkg.sv
package dtr_pkg;
  typedef enum logic [1:0] {
    DTR_ENA = 2'd0,
    DTR_TRG = 2'd1,
    DTR_SEL = 2'd2,
    DTR_RSV = 2'd3
  } dtr_addr_e;
endpackage

// File: rtl/dtr_regs.sv
module dtr_regs #(
  parameter int NUM_CH = 4,
  parameter int SEL_W  = 2,
  localparam int WD    = NUM_CH * SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [WD-1:0]     wr_data,
  output logic [NUM_CH-1:0] ch_on,
  output logic [WD-1:0]     sel_flat,
  output logic [NUM_CH-1:0] sw_set
);
  import dtr_pkg::*;

  dtr_addr_e addr;
  assign addr = dtr_addr_e'(wr_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_on    <= '0;
      sel_flat <= '0;
    end else if (wr_en) begin
      if (addr == DTR_ENA) ch_on    <= wr_data[NUM_CH-1:0];
      if (addr == DTR_SEL) sel_flat <= wr_data;
    end
  end

  // Software trigger pulse: only ones have an effect.
  always_comb begin
    sw_set = '0;
    if (wr_en && addr == DTR_TRG) sw_set = wr_data[NUM_CH-1:0];
  end
endmodule

// File: rtl/dtr_edge.sv
module dtr_edge #(
  parameter int NUM_CH = 4,
  parameter int SEL_W  = 2,
  localparam int SPC   = 1 << SEL_W,
  localparam int NSRC  = NUM_CH * SPC
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NSRC-1:0]         src,
  input  logic [NUM_CH*SEL_W-1:0] sel_flat,
  output logic [NUM_CH-1:0]       hw_set
);
  logic [NSRC-1:0] prev;
  logic [NSRC-1:0] rise;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= src;
  end

  assign rise = src & ~prev;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [SPC-1:0]   grp;
    logic [SEL_W-1:0] pick;
    assign grp       = rise[c*SPC +: SPC];
    assign pick      = sel_flat[c*SEL_W +: SEL_W];
    assign hw_set[c] = grp[pick];
  end
endmodule

// File: rtl/dtr_flag.sv
module dtr_flag #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] sw_set,
  input  logic [NUM_CH-1:0] hw_set,
  input  logic [NUM_CH-1:0] ch_on,
  input  logic [NUM_CH-1:0] chen,
  input  logic [NUM_CH-1:0] ack,
  output logic [NUM_CH-1:0] flag,
  output logic [NUM_CH-1:0] req
);
  logic [NUM_CH-1:0] armed, fire, taken, flag_n;

  always_comb begin
    armed  = ch_on & chen;
    fire   = (sw_set | hw_set) & armed;
    taken  = flag & armed & ack;
    flag_n = fire | (flag & ~taken);
  end

  always_ff @(posedge clk) begin
    if (rst) flag <= '0;
    else     flag <= flag_n;
  end

  assign req = flag & armed;
endmodule

// File: rtl/dma_trig_req.sv
module dma_trig_req #(
  parameter int NUM_CH = 4,
  parameter int SEL_W  = 2,
  localparam int WD    = NUM_CH * SEL_W,
  localparam int NSRC  = NUM_CH * (1 << SEL_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [WD-1:0]     wr_data,
  input  logic [NSRC-1:0]   hw_src,
  input  logic [NUM_CH-1:0] chen,
  input  logic [NUM_CH-1:0] ack,
  output logic [NUM_CH-1:0] req,
  output logic [NUM_CH-1:0] trg_pend
);
  logic [NUM_CH-1:0] ch_on, sw_set, hw_set;
  logic [WD-1:0]     sel_flat;

  dtr_regs #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ch_on(ch_on), .sel_flat(sel_flat), .sw_set(sw_set)
  );

  dtr_edge #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_edge (
    .clk(clk), .rst(rst), .src(hw_src), .sel_flat(sel_flat), .hw_set(hw_set)
  );

  dtr_flag #(.NUM_CH(NUM_CH)) u_flag (
    .clk(clk), .rst(rst), .sw_set(sw_set), .hw_set(hw_set), .ch_on(ch_on),
    .chen(chen), .ack(ack), .flag(trg_pend), .req(req)
  );
endmodule

// File: rtl/dma_trig_req_chk.sv
module dma_trig_req_chk #(
  parameter int NUM_CH = 4,
  parameter int SEL_W  = 2,
  localparam int SPC   = 1 << SEL_W,
  localparam int NSRC  = NUM_CH * SPC
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [NUM_CH-1:0] wr_bits,
  input logic [NSRC-1:0]   hw_src,
  input logic [NUM_CH-1:0] chen,
  input logic [NUM_CH-1:0] ack,
  input logic [NUM_CH-1:0] req,
  input logic [NUM_CH-1:0] trg_pend
);
  logic [NSRC-1:0] prv;
  always_ff @(posedge clk) begin
    if (rst) prv <= '0;
    else     prv <= hw_src;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    logic sw_c, rise_c;
    assign sw_c   = wr_en && (wr_addr == 2'd1) && wr_bits[c];
    assign rise_c = |(hw_src[c*SPC +: SPC] & ~prv[c*SPC +: SPC]);

    // R3 / R4: no event means no new pending flag
    a_r4_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
      (!trg_pend[c] && !sw_c && !rise_c) |=> !trg_pend[c]);
    // R6: no set while the descriptor enable is low
    a_r6_chen_gate: assert property (@(posedge clk) disable iff (rst)
      (!trg_pend[c] && !chen[c]) |=> !trg_pend[c]);
    // R7: a request implies a pending flag and an enabled descriptor
    a_r7_req_gated: assert property (@(posedge clk) disable iff (rst)
      req[c] |-> (trg_pend[c] && chen[c]));
    // R8: the flag is held until acceptance
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
      (trg_pend[c] && !ack[c]) |=> trg_pend[c]);
    // R8: acceptance without a new event clears the flag
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
      (req[c] && ack[c] && !sw_c && !rise_c) |=> !trg_pend[c]);
    // R9: an event at acceptance keeps the flag
    a_r9_keep: assert property (@(posedge clk) disable iff (rst)
      (req[c] && ack[c] && sw_c) |=> trg_pend[c]);
  end
endmodule

bind dma_trig_req dma_trig_req_chk #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_bits(wr_data[NUM_CH-1:0]), .hw_src(hw_src), .chen(chen), .ack(ack),
  .req(req), .trg_pend(trg_pend)
);

// File: tb/dma_trig_req_bench.sv
`timescale 1ns/1ps
module dma_trig_req_bench;
  localparam int N    = 3;
  localparam int SW   = 2;
  localparam int SPC  = 1 << SW;
  localparam int WD   = N * SW;
  localparam int NSRC = N * SPC;

  logic            clk = 1'b0;
  logic            rst;
  logic            wr_en;
  logic [1:0]      wr_addr;
  logic [WD-1:0]   wr_data;
  logic [NSRC-1:0] hw_src;
  logic [N-1:0]    chen, ack, req, trg_pend;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dma_trig_req #(.NUM_CH(N), .SEL_W(SW)) u_dma_trig_req (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hw_src(hw_src), .chen(chen), .ack(ack), .req(req), .trg_pend(trg_pend)
  );

  // Reference model built from the requirements
  logic [N-1:0]    m_on, m_flag;
  logic [WD-1:0]   m_sel;
  logic [NSRC-1:0] m_prev;

  function automatic logic next_flag(logic f, logic on, logic ce, logic sw,
                                     logic hw, logic ak);
    logic arm;
    arm = on & ce;
    return ((sw | hw) & arm) | (f & ~(f & arm & ak));
  endfunction

  function automatic logic hw_event(logic [NSRC-1:0] s, logic [NSRC-1:0] p,
                                    logic [WD-1:0] sel, int c);
    int idx;
    idx = c * SPC + int'(sel[c*SW +: SW]);
    return s[idx] & ~p[idx];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_on <= '0; m_flag <= '0; m_sel <= '0; m_prev <= '0;
    end else begin
      for (int c = 0; c < N; c++)
        m_flag[c] <= next_flag(m_flag[c], m_on[c], chen[c],
                               wr_en && wr_addr == 2'd1 && wr_data[c],
                               hw_event(hw_src, m_prev, m_sel, c), ack[c]);
      if (wr_en && wr_addr == 2'd0) m_on  <= wr_data[N-1:0];
      if (wr_en && wr_addr == 2'd2) m_sel <= wr_data;
      m_prev <= hw_src;
    end
  end

  task automatic check(string tag, logic [N-1:0] got, logic [N-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 1'b0; wr_addr = 2'd0; wr_data = '0; ack = '0;
  endtask

  task automatic wr(logic [1:0] a, logic [WD-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
  endtask

  initial begin
    #100us;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1..: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; idle(); hw_src = '0; chen = '1;
    repeat (3) step();
    rst = 1'b0;
    step();
    check("R1 pend after reset", trg_pend, 3'b000);
    check("R1 req after reset", req, 3'b000);

    // R6: controller enable still 0 after reset
    wr(2'd1, 6'b000001); step(); idle();
    check("R6 trigger while disabled", trg_pend, 3'b000);

    // R10 enable all, R2 software trigger, R7 request
    wr(2'd0, 6'b000111); step();
    wr(2'd1, 6'b000001); step(); idle();
    check("R2 sw trigger sets", trg_pend, 3'b001);
    check("R7 req follows flag", req, 3'b001);

    // R3 writing zero keeps the flag
    wr(2'd1, 6'b000000); step(); idle();
    check("R3 zero write no effect", trg_pend, 3'b001);

    // R8 acceptance clears
    ack = 3'b001; step(); idle();
    check("R8 clear on ack", trg_pend, 3'b000);

    // R5 selector ch1 = 2; unselected line ignored
    wr(2'd2, 6'b001000); step(); idle();
    hw_src[4] = 1'b1; step();
    check("R5 unselected line ignored", trg_pend, 3'b000);
    hw_src[4] = 1'b0;
    hw_src[6] = 1'b1; step();
    check("R4 selected edge sets", trg_pend, 3'b010);
    ack = 3'b010; step(); idle();
    check("R8 clear ch1", trg_pend, 3'b000);
    step(); step();
    check("R4 held level sets once", trg_pend, 3'b000);
    hw_src = '0;

    // R6 chen low discards
    chen = 3'b011; wr(2'd1, 6'b000100); step(); idle();
    check("R6 chen low discards", trg_pend, 3'b000);
    chen = 3'b111;

    // R9 event at acceptance
    wr(2'd1, 6'b000001); step();
    ack = 3'b001; wr(2'd1, 6'b000001); step(); idle();
    check("R9 flag kept at ack", trg_pend, 3'b001);

    // R7 req drops with chen while flag stays
    chen = 3'b110; #1;
    check("R7 req gated by chen", req, 3'b000);
    check("R7 flag kept with chen low", trg_pend, 3'b001);
    chen = 3'b111; #1;
    check("R7 req back with chen", req, 3'b001);

    // R10 whole register load; address 3 ignored
    wr(2'd0, 6'b000101); step();
    wr(2'd3, 6'b111111); step();
    wr(2'd1, 6'b000010); step(); idle();
    check("R10 disabled ch1 ignores trigger", trg_pend, 3'b001);
    check("R10 req pattern", req, 3'b001);

    // Random phase against the model
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 3000; i++) begin
      wr_en   = ($urandom % 3) == 0;
      wr_addr = 2'($urandom % 4);
      wr_data = WD'($urandom);
      hw_src  = NSRC'($urandom) & NSRC'($urandom);
      chen    = N'($urandom) | N'($urandom);
      ack     = N'($urandom);
      step();
      check("R2 random pend vs model", trg_pend, m_flag);
      check("R7 random req vs model", req, m_flag & m_on & chen);
    end
    idle();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule